// File: doc/BRIEF.md
# Voltage Regulator Soft-Start and Power-Good Sequencer

This block runs the digital start-up of a voltage regulator controller. It holds still until a supply-ok input and an enable input are both high. It then moves a 12-bit DAC target code up in fixed steps, one step per 1 µs tick. In CPU mode the code first climbs to a fixed boot level. The sampled output voltage must then sit inside a ±10 % band around that level for 13 consecutive PWM-cycle samples. When it has, the active-low clock-enable output is driven low and the code moves on to the VID code. In GPU mode the code climbs straight to the VID code, and clock enable follows the same band check around that code. Power-good rises once enough ticks have passed since the ramp began and the sequencer has reached its final state.

The DAC code has a 0.5 mV LSB. The boot level of 1.1 V is code 2200. Slew is applied on each tick, and the final step always stops exactly on the target. The step sizes are:
- 5 LSB per tick (2.5 mV/µs) towards the boot level.
- 10 LSB per tick (5 mV/µs) towards the VID code.
- 20 LSB per tick in GPU mode while the sleep-state input is high.

When enable is already high at the moment supply-ok rises, the ramp starts only after a delay of 120 ticks. When either input drops, the block returns to idle.

States, with the `state_o` code of each:

| State | Code | Meaning |
|---|---|---|
| IDLE | 0 | Waiting for supply-ok and enable. |
| AUTO_DELAY | 1 | Counting the start delay. |
| RAMP_BOOT | 2 | Climbing to the boot level. |
| WAIT_WINDOW | 3 | Counting in-band PWM samples. |
| RAMP_VID | 4 | Moving to the VID code. |
| RUN | 5 | Tracking the VID code. |

Transitions:

| From | To | Condition |
|---|---|---|
| IDLE | RAMP_BOOT or RAMP_VID (start) | Both inputs high, and supply-ok was already high on the previous clock. |
| IDLE | AUTO_DELAY (strapped start) | Both inputs high, and supply-ok has just risen. |
| AUTO_DELAY | RAMP_BOOT or RAMP_VID (start) | The delay count is complete. |
| RAMP_BOOT | WAIT_WINDOW | The code equals the boot level. |
| WAIT_WINDOW | RAMP_VID | Band check passed, CPU mode. |
| WAIT_WINDOW | RUN | Band check passed, GPU mode. |
| RAMP_VID | RUN | The code equals the VID code and clock enable is already low. |
| RAMP_VID | WAIT_WINDOW | The code equals the VID code and clock enable is still high. |
| Any state | IDLE (abort) | Supply-ok or enable is low. |

Top module: `vr_softstart_seq`

## Requirements
- R1: After reset, and while supply-ok or enable is low, `state_o` is 0, `dac_code` is 0, `clk_en_n` is 1 and `pgood` is 0.
- R2: If enable is high while supply-ok was already high on the previous clock, the state leaves IDLE on the next clock. If supply-ok rises while enable is high, the state becomes AUTO_DELAY (1) and holds there for AUTO_TICKS ticks before the ramp starts.
- R3: In CPU mode (`gpu_mode`=0) the ramp starts in RAMP_BOOT (2) and adds 5 to `dac_code` on each tick, up to BOOT_CODE (2200).
- R4: A step never passes its target. The last step lands exactly on the target, whether the target is BOOT_CODE or `vid_code`.
- R5: In WAIT_WINDOW (3), each `pwm_cycle` pulse samples `vout_code`. A sample counts as in band when it lies between c − floor(c/10) and c + floor(c/10), bounds included, where c is the current DAC code. An out-of-band sample clears the count. On the clock of the 13th consecutive in-band sample, the sequencer leaves the state and `clk_en_n` goes low.
- R6: In CPU mode, after the band check, the state is RAMP_VID (4) and the code moves 10 per tick to `vid_code`. The state then becomes RUN (5).
- R7: In GPU mode the ramp starts in RAMP_VID with no boot step. The step is 10 per tick, or 20 while `sleep_state` is 1. On reaching `vid_code` the state goes to WAIT_WINDOW, then to RUN with `clk_en_n` low.
- R8: `pgood` rises on the clock after both of these hold: PG_TICKS ticks have been counted since the ramp started, and the state is RUN. It is never high while `clk_en_n` is high.
- R9: In RUN, `dac_code` follows changes of `vid_code` in both directions at the current step. In CPU mode the step is 10. In GPU mode it is 10 or 20, chosen by `sleep_state`.
- R10: Dropping supply-ok or enable in any state gives, on the next clock, state IDLE, `dac_code` 0, `clk_en_n` 1 and `pgood` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_1us | input | 1 | One-cycle pulse every microsecond |
| pwm_cycle | input | 1 | One-cycle pulse per PWM period |
| por_ok | input | 1 | Supply above its reset threshold |
| vr_enable | input | 1 | Regulator enable |
| gpu_mode | input | 1 | 1 selects GPU sequencing, 0 selects CPU sequencing |
| sleep_state | input | 1 | Doubles the GPU-mode slew |
| vid_code | input | 12 | Final DAC code |
| vout_code | input | 12 | Digitised output voltage, same LSB as the DAC |
| dac_code | output | 12 | DAC target code |
| clk_en_n | output | 1 | Active-low clock enable |
| pgood | output | 1 | Power good |
| state_o | output | 3 | Current state code |

## Verification
Some properties can be checked on every clock, and the assertions cover them:
- A step is never larger than the selected slew, and a step never passes its target.
- The in-band count never goes past its limit, and an out-of-band sample clears it.
- A dropped input leaves every output idle on the next clock.
- Power-good is never high while clock enable is released.

Other behaviour can only be shown by running scenarios against the cycle model:
- The two start paths: the delayed start after supply-ok rises, and the immediate start.
- The boot-then-VID order in CPU mode.
- The sleep-state doubling in GPU mode.
- The inclusive band edge.
- VID tracking in both directions.
- The delay between reaching RUN and power-good.

// File: rtl/vrs_pkg.sv
package vrs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE        = 3'd0,
        ST_AUTO_DELAY  = 3'd1,
        ST_RAMP_BOOT   = 3'd2,
        ST_WAIT_WINDOW = 3'd3,
        ST_RAMP_VID    = 3'd4,
        ST_RUN         = 3'd5
    } seq_state_e;
endpackage

// File: rtl/vrs_tick_count.sv
// Saturating counter of tick pulses; reached is high once LIMIT ticks were seen.
module vrs_tick_count #(
    parameter int LIMIT = 120
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic tick,
    output logic reached
);
    localparam int CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] LIM = CNT_W'(LIMIT);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
        end else if (tick && cnt_q != LIM) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign reached = (cnt_q == LIM);

    // the counter saturates at its limit
    assert_tick_sat_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LIM);
endmodule

// File: rtl/vrs_slew.sv
// DAC code register stepping toward a target by at most step per advance.
module vrs_slew #(
    parameter int CODE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              advance,
    input  logic [CODE_W-1:0] target,
    input  logic [CODE_W-1:0] step,
    output logic [CODE_W-1:0] dac_code,
    output logic              at_target
);
    logic [CODE_W-1:0] dac_q;
    logic [CODE_W-1:0] dac_d;
    logic [CODE_W-1:0] gap_up;
    logic [CODE_W-1:0] gap_dn;

    assign gap_up = target - dac_q;
    assign gap_dn = dac_q - target;

    always_comb begin
        dac_d = dac_q;
        if (clear) begin
            dac_d = '0;
        end else if (advance) begin
            if (dac_q < target) begin
                dac_d = (gap_up > step) ? dac_q + step : target;
            end else if (dac_q > target) begin
                dac_d = (gap_dn > step) ? dac_q - step : target;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) dac_q <= '0;
        else        dac_q <= dac_d;
    end

    assign dac_code  = dac_q;
    assign at_target = (dac_q == target);

    // a single move never exceeds the selected step
    assert_step_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(advance && !clear) |->
        (((dac_q >= $past(dac_q)) ? (dac_q - $past(dac_q)) : ($past(dac_q) - dac_q))
         <= $past(step)));

    // an upward move never lands above its target
    assert_no_overshoot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(advance && !clear && (dac_q <= target)) |-> dac_q <= $past(target));

    // a downward move never lands below its target
    assert_no_undershoot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(advance && !clear && (dac_q >= target)) |-> dac_q >= $past(target));
endmodule

// File: rtl/vrs_window.sv
// Counts consecutive in-band output samples around a centre code.
module vrs_window #(
    parameter int CODE_W     = 12,
    parameter int WIN_CYCLES = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              sample,
    input  logic [CODE_W-1:0] center,
    input  logic [CODE_W-1:0] vout,
    output logic              done
);
    localparam int CW = $clog2(WIN_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(WIN_CYCLES - 1);
    localparam logic [CW-1:0] FULL = CW'(WIN_CYCLES);

    logic [CW-1:0]     cnt_q;
    logic [CODE_W:0]   tenth;
    logic [CODE_W:0]   lo_b;
    logic [CODE_W:0]   hi_b;
    logic              in_band;

    assign tenth   = {1'b0, center} / (CODE_W+1)'(10);
    assign lo_b    = {1'b0, center} - tenth;
    assign hi_b    = {1'b0, center} + tenth;
    assign in_band = ({1'b0, vout} >= lo_b) && ({1'b0, vout} <= hi_b);

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
        end else if (sample) begin
            if (!in_band)           cnt_q <= '0;
            else if (cnt_q != FULL) cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = !clear && sample && in_band && (cnt_q == LAST);

    assert_count_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= FULL);

    // an out-of-band sample clears the run
    assert_reset_on_miss_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sample && !in_band && !clear) |=> cnt_q == '0);
endmodule

// File: rtl/vr_softstart_seq.sv
module vr_softstart_seq
    import vrs_pkg::*;
#(
    parameter int CODE_W     = 12,
    parameter int BOOT_CODE  = 2200,
    parameter int WIN_CYCLES = 13,
    parameter int AUTO_TICKS = 120,
    parameter int PG_TICKS   = 7000,
    parameter int STEP_BOOT  = 5,
    parameter int STEP_NORM  = 10,
    parameter int STEP_FAST  = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1us,
    input  logic              pwm_cycle,
    input  logic              por_ok,
    input  logic              vr_enable,
    input  logic              gpu_mode,
    input  logic              sleep_state,
    input  logic [CODE_W-1:0] vid_code,
    input  logic [CODE_W-1:0] vout_code,
    output logic [CODE_W-1:0] dac_code,
    output logic              clk_en_n,
    output logic              pgood,
    output logic [2:0]        state_o
);
    localparam logic [CODE_W-1:0] BOOT_C = CODE_W'(BOOT_CODE);
    localparam logic [CODE_W-1:0] S_BOOT = CODE_W'(STEP_BOOT);
    localparam logic [CODE_W-1:0] S_NORM = CODE_W'(STEP_NORM);
    localparam logic [CODE_W-1:0] S_FAST = CODE_W'(STEP_FAST);

    seq_state_e        state_q, state_d, start_st;
    logic              go;
    logic              por_q;
    logic              gpu_q;
    logic              clk_en_n_q;
    logic              pgood_q;
    logic              waiting;
    logic              slewing;
    logic              auto_done;
    logic              pg_done;
    logic              win_done;
    logic              at_target;
    logic [CODE_W-1:0] tgt;
    logic [CODE_W-1:0] step;
    logic [CODE_W-1:0] dac_w;

    assign go       = por_ok && vr_enable;
    assign waiting  = (state_q == ST_IDLE) || (state_q == ST_AUTO_DELAY);
    assign slewing  = (state_q == ST_RAMP_BOOT) || (state_q == ST_RAMP_VID) || (state_q == ST_RUN);
    assign start_st = gpu_mode ? ST_RAMP_VID : ST_RAMP_BOOT;
    assign tgt      = (state_q == ST_RAMP_BOOT) ? BOOT_C : vid_code;
    assign step     = (state_q == ST_RAMP_BOOT) ? S_BOOT :
                      (gpu_q && sleep_state)    ? S_FAST : S_NORM;

    vrs_tick_count #(.LIMIT(AUTO_TICKS)) u_auto_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (!go || state_q != ST_AUTO_DELAY),
        .tick    (tick_1us),
        .reached (auto_done)
    );

    vrs_tick_count #(.LIMIT(PG_TICKS)) u_pg_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (!go || waiting),
        .tick    (tick_1us),
        .reached (pg_done)
    );

    vrs_slew #(.CODE_W(CODE_W)) u_slew (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (!go || waiting),
        .advance   (tick_1us && slewing),
        .target    (tgt),
        .step      (step),
        .dac_code  (dac_w),
        .at_target (at_target)
    );

    vrs_window #(.CODE_W(CODE_W), .WIN_CYCLES(WIN_CYCLES)) u_window (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (!go || state_q != ST_WAIT_WINDOW),
        .sample (pwm_cycle),
        .center (dac_w),
        .vout   (vout_code),
        .done   (win_done)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (!go) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:        state_d = por_q ? start_st : ST_AUTO_DELAY;
                ST_AUTO_DELAY:  if (auto_done) state_d = start_st;
                ST_RAMP_BOOT:   if (at_target) state_d = ST_WAIT_WINDOW;
                ST_WAIT_WINDOW: if (win_done)  state_d = gpu_q ? ST_RUN : ST_RAMP_VID;
                ST_RAMP_VID:    if (at_target) state_d = clk_en_n_q ? ST_WAIT_WINDOW : ST_RUN;
                ST_RUN:         state_d = ST_RUN;
                default:        state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // output and mode registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            por_q      <= 1'b0;
            gpu_q      <= 1'b0;
            clk_en_n_q <= 1'b1;
            pgood_q    <= 1'b0;
        end else begin
            por_q   <= por_ok;
            pgood_q <= go && (state_q == ST_RUN) && pg_done;
            if (waiting) gpu_q <= gpu_mode;
            if (!go || waiting)                             clk_en_n_q <= 1'b1;
            else if (state_q == ST_WAIT_WINDOW && win_done) clk_en_n_q <= 1'b0;
        end
    end

    assign dac_code = dac_w;
    assign clk_en_n = clk_en_n_q;
    assign pgood    = pgood_q;
    assign state_o  = state_q;

    // a dropped input idles every output on the next clock
    assert_abort_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !go |=> (state_q == ST_IDLE) && (dac_w == '0) && clk_en_n_q && !pgood_q);

    assert_pgood_after_clken_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pgood_q |-> !clk_en_n_q);

    // clock enable is only active once the band check has passed
    assert_clken_late_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en_n_q |-> (state_q == ST_RAMP_VID) || (state_q == ST_RUN));

    assert_boot_cpu_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RAMP_BOOT) |-> !gpu_q);
endmodule

// File: tb/vr_softstart_seq_tb.sv
`timescale 1ns/1ps
module vr_softstart_seq_tb;
    localparam int PGT = 600;
    localparam int AT  = 120;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_1us = 1'b0;
    logic        pwm_cycle = 1'b0;
    logic        por_ok = 1'b0;
    logic        vr_enable = 1'b0;
    logic        gpu_mode = 1'b0;
    logic        sleep_state = 1'b0;
    logic [11:0] vid_code = 12'd0;
    logic [11:0] vout_code = 12'd0;
    logic [11:0] dac_code;
    logic        clk_en_n;
    logic        pgood;
    logic [2:0]  state_o;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit finished = 0;

    vr_softstart_seq #(.PG_TICKS(PGT), .AUTO_TICKS(AT)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_1us(tick_1us), .pwm_cycle(pwm_cycle),
        .por_ok(por_ok), .vr_enable(vr_enable), .gpu_mode(gpu_mode),
        .sleep_state(sleep_state), .vid_code(vid_code), .vout_code(vout_code),
        .dac_code(dac_code), .clk_en_n(clk_en_n), .pgood(pgood), .state_o(state_o));

    always #2.5 clk = ~clk;

    // tick every 10 clocks, PWM sample every 7 clocks
    initial begin
        int tc = 0;
        int pc = 0;
        forever begin
            @(negedge clk);
            tc = (tc == 9) ? 0 : tc + 1;
            pc = (pc == 6) ? 0 : pc + 1;
            tick_1us  = (tc == 0);
            pwm_cycle = (pc == 0);
        end
    end

    // behavioural reference model
    int m_st = 0, m_dac = 0, m_win = 0, m_auto = 0, m_pg = 0;
    int m_clkn = 1, m_pgood = 0, m_gpu = 0, m_por = 0;

    always @(posedge clk) begin
        int go, tg, stp, lo, hi, inb, done, n_st, n_dac, n_win, n_auto, n_pg;
        if (!rst_n) begin
            m_st = 0; m_dac = 0; m_win = 0; m_auto = 0; m_pg = 0;
            m_clkn = 1; m_pgood = 0; m_gpu = 0; m_por = 0;
        end else begin
            go  = (por_ok && vr_enable) ? 1 : 0;
            tg  = (m_st == 2) ? 2200 : int'(vid_code);
            stp = (m_st == 2) ? 5 : ((m_gpu == 1 && sleep_state) ? 20 : 10);
            n_dac = m_dac;
            if (!go || m_st <= 1) n_dac = 0;
            else if (tick_1us && m_st != 3) begin
                if (m_dac < tg)      n_dac = (tg - m_dac > stp) ? m_dac + stp : tg;
                else if (m_dac > tg) n_dac = (m_dac - tg > stp) ? m_dac - stp : tg;
            end
            lo  = m_dac - m_dac / 10;
            hi  = m_dac + m_dac / 10;
            inb = (int'(vout_code) >= lo && int'(vout_code) <= hi) ? 1 : 0;
            done = (go && m_st == 3 && pwm_cycle && inb && m_win == 12) ? 1 : 0;
            n_win = m_win;
            if (!go || m_st != 3) n_win = 0;
            else if (pwm_cycle) n_win = inb ? m_win + 1 : 0;
            n_auto = m_auto;
            if (!go || m_st != 1) n_auto = 0;
            else if (tick_1us && m_auto < AT) n_auto = m_auto + 1;
            n_pg = m_pg;
            if (!go || m_st <= 1) n_pg = 0;
            else if (tick_1us && m_pg < PGT) n_pg = m_pg + 1;
            n_st = m_st;
            if (!go) n_st = 0;
            else case (m_st)
                0: n_st = m_por ? (gpu_mode ? 4 : 2) : 1;
                1: if (m_auto == AT) n_st = gpu_mode ? 4 : 2;
                2: if (m_dac == 2200) n_st = 3;
                3: if (done) n_st = m_gpu ? 5 : 4;
                4: if (m_dac == int'(vid_code)) n_st = m_clkn ? 3 : 5;
                default: n_st = 5;
            endcase
            m_pgood = (go && m_st == 5 && m_pg == PGT) ? 1 : 0;
            if (m_st <= 1) m_gpu = gpu_mode ? 1 : 0;
            if (!go || m_st <= 1) m_clkn = 1;
            else if (done) m_clkn = 0;
            m_por = por_ok ? 1 : 0;
            m_st = n_st; m_dac = n_dac; m_win = n_win; m_auto = n_auto; m_pg = n_pg;
        end
    end

    task automatic chk(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d at cycle %0d", req, what, act, exp, cyc);
        end
    endtask

    function automatic string tag_of(input int s);
        case (s)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            3: return "R5";
            4: return (m_gpu == 1) ? "R7" : "R6";
            default: return "R9";
        endcase
    endfunction

    // compare against the model on every clock, away from the active edge
    always @(negedge clk) begin
        cyc++;
        if (rst_n && !finished) begin
            chk(tag_of(m_st), int'(state_o), m_st, "state");
            chk(tag_of(m_st), int'(dac_code), m_dac, "dac_code");
            chk("R5", int'(clk_en_n), m_clkn, "clk_en_n");
            chk("R8", int'(pgood), m_pgood, "pgood");
        end
        if (cyc > 150000 && !finished) begin
            finished = 1;
            errors++;
            $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cyc, 150000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic wait_state(input int s);
        while (int'(state_o) != s) @(negedge clk);
    endtask

    task automatic wait_dac(input int v);
        while (int'(dac_code) != v) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", int'(state_o), 0, "reset state");
        chk("R1", int'(dac_code), 0, "reset dac");
        chk("R1", int'(clk_en_n), 1, "reset clk_en_n");
        chk("R1", int'(pgood), 0, "reset pgood");

        // CPU, supply already up, enable rises later
        vid_code = 12'd2405; vout_code = 12'd2200; por_ok = 1'b1;
        repeat (20) @(negedge clk);
        chk("R1", int'(state_o), 0, "idle without enable");
        vr_enable = 1'b1;
        @(negedge clk);
        chk("R2", int'(state_o), 2, "immediate start");
        wait_state(3);
        chk("R3", int'(dac_code), 2200, "boot level reached");
        vout_code = 12'd1980;           // lower band edge, inclusive
        repeat (35) @(negedge clk);
        vout_code = 12'd1979;           // one below band: restarts count
        repeat (7) @(negedge clk);
        vout_code = 12'd2420;           // upper band edge, inclusive
        wait_state(4);
        chk("R5", int'(clk_en_n), 0, "clock enable after band check");
        wait_state(5);
        chk("R4", int'(dac_code), 2405, "clamped at vid");
        chk("R6", int'(clk_en_n), 0, "cpu run");
        while (!pgood) @(negedge clk);
        chk("R8", int'(state_o), 5, "pgood in run");
        vid_code = 12'd2000;
        wait_dac(2000);
        chk("R9", int'(state_o), 5, "tracked down");
        vid_code = 12'd2103;
        wait_dac(2103);
        chk("R9", int'(dac_code), 2103, "tracked up");
        vr_enable = 1'b0;
        @(negedge clk);
        chk("R10", int'(state_o), 0, "abort state");
        chk("R10", int'(dac_code), 0, "abort dac");
        chk("R10", int'(clk_en_n), 1, "abort clk_en_n");
        chk("R10", int'(pgood), 0, "abort pgood");

        // GPU, enable strapped high, supply rises
        por_ok = 1'b0; gpu_mode = 1'b1; sleep_state = 1'b1;
        vid_code = 12'd1500; vout_code = 12'd1500;
        @(negedge clk);
        vr_enable = 1'b1;
        repeat (10) @(negedge clk);
        chk("R1", int'(state_o), 0, "idle without supply");
        por_ok = 1'b1;
        @(negedge clk);
        chk("R2", int'(state_o), 1, "strapped start delay");
        repeat (AT * 10 - 40) @(negedge clk);
        chk("R2", int'(state_o), 1, "still delaying");
        wait_state(4);
        wait_state(3);
        chk("R7", int'(dac_code), 1500, "gpu reached vid");
        chk("R7", int'(clk_en_n), 1, "no clock enable yet");
        wait_state(5);
        chk("R7", int'(clk_en_n), 0, "gpu run");
        chk("R8", int'(pgood), 0, "pgood waits for ticks");
        sleep_state = 1'b0; vid_code = 12'd1633;
        wait_dac(1633);
        chk("R9", int'(dac_code), 1633, "gpu tracking normal slew");
        while (!pgood) @(negedge clk);
        chk("R8", int'(clk_en_n), 0, "gpu pgood");
        repeat (5) @(negedge clk);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule